// File: doc/BRIEF.md
# Bus access wait-state generator

This block sets the length of every access on a 32-bit-address system bus that is split into several memory regions. A requester presents an address, a word/halfword size flag and a sequential flag, together with the current wait configuration. The block works out how many bus clocks the access needs and counts them off. It holds `busy` for exactly that many cycles and pulses `done` in the last one.

Most regions have a fixed or size-dependent length. The external work-RAM region has a programmable length. The four cartridge windows each use a programmable non-sequential lookup and a two-way sequential choice. A sequential access that starts on a 128 KB page edge is treated as non-sequential. A word access through the 16-bit cartridge path pays for a second, sequential transfer.

Top module: `bus_wait_gen`

## Requirements
- R1: An access at an address of 0x1000_0000 or above, or below 0x0200_0000, lasts 1 cycle whatever its size.
- R2: An access in 0x0200_0000–0x02FF_FFFF lasts (16 − cfg_wram_wait) cycles for a halfword and twice that for a word, so a setting of 0 gives 16 or 32 cycles.
- R3: An access in 0x0300_0000–0x04FF_FFFF or in 0x0700_0000–0x07FF_FFFF lasts 1 cycle. An access in 0x0500_0000–0x06FF_FFFF lasts 2 cycles for a word and 1 for a halfword.
- R4: In 0x0800_0000–0x0FFF_FFFF the window index is addr[26:25]. The non-sequential length is 5, 4, 3 or 9 for the window's 2-bit setting cfg_ns_sel[2i+1:2i] equal to 0, 1, 2 or 3.
- R5: The sequential length of windows 0, 1 and 2 is 2 when cfg_seq_sel[i] is 1, and 3, 5 or 9 respectively when it is 0. The sequential length of window 3 always equals its non-sequential length.
- R6: A cartridge access whose addr[16:1] are all zero uses the non-sequential length even when req_seq is 1.
- R7: A cartridge word access lasts its first-transfer length (sequential or non-sequential) plus the window's sequential length.
- R8: A request is taken only while `busy` is low. A request presented while busy does not change the running access.
- R9: After a request is taken at a clock edge, `busy` is high for exactly the computed number of cycles, and `done` is high for one cycle only: the last of them.
- R10: The wait configuration is captured when the request is taken. Changes made to it during the access do not alter the access length.
- R11: Synchronous active-high `rst` forces `busy` and `done` low and abandons any access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_addr | input | 32 | Access address |
| req_word | input | 1 | 1 = 32-bit word, 0 = halfword/byte |
| req_seq | input | 1 | 1 = follows the previous access in sequence |
| cfg_wram_wait | input | 4 | Work-RAM wait setting |
| cfg_ns_sel | input | 8 | Non-sequential setting, 2 bits per cartridge window |
| cfg_seq_sel | input | 4 | Sequential setting, 1 bit per cartridge window |
| busy | output | 1 | Access in progress |
| done | output | 1 | High in the final cycle of an access |

## Verification
The hardest conditions to reach are a request or a configuration change that lands in the middle of a running access. Requests arrive one per access from a simple driver, so a second request never overlaps a live one on its own. The stimulus therefore pokes a second request, and separately rewrites the whole configuration, in the cycle after acceptance of a long access. Page-edge addresses with the sequential flag set are aimed at directly, with and without address bit 0, next to their non-edge neighbours.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int ADDR_W       = 32;
  localparam int WRAM_W       = 4;
  localparam int CART_REGIONS = 4;
  localparam int NS_SEL_W     = 2;
  localparam int WRAM_SPAN    = 1 << WRAM_W;
  localparam int CNT_W        = $clog2(2 * WRAM_SPAN + 1);
  localparam int SEQ_FAST     = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t ns_lookup(input logic [NS_SEL_W-1:0] sel);
    case (sel)
      2'd0:    return cnt_t'(5);
      2'd1:    return cnt_t'(4);
      2'd2:    return cnt_t'(3);
      default: return cnt_t'(9);
    endcase
  endfunction

  function automatic cnt_t seq_slow(input int region);
    case (region)
      0:       return cnt_t'(3);
      1:       return cnt_t'(5);
      default: return cnt_t'(9);
    endcase
  endfunction
endpackage

// File: rtl/bwg_cart_timing.sv
module bwg_cart_timing
  import bwg_pkg::*;
(
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             word,
  input  logic                             seq,
  input  logic [NS_SEL_W*CART_REGIONS-1:0] ns_sel,
  input  logic [CART_REGIONS-1:0]          s_sel,
  output cnt_t                             count
);
  localparam int IDX_W = $clog2(CART_REGIONS);

  cnt_t n_len [CART_REGIONS];
  cnt_t s_len [CART_REGIONS];
  logic [IDX_W-1:0] idx;
  logic page_edge;
  cnt_t first_len;

  for (genvar g = 0; g < CART_REGIONS; g++) begin : g_win
    assign n_len[g] = ns_lookup(ns_sel[NS_SEL_W*g +: NS_SEL_W]);
    if (g == CART_REGIONS - 1) begin : g_last
      assign s_len[g] = n_len[g];
    end else begin : g_fast
      assign s_len[g] = s_sel[g] ? cnt_t'(SEQ_FAST) : seq_slow(g);
    end
  end

  assign idx       = addr[25 +: IDX_W];
  assign page_edge = (addr[16:1] == 16'd0);
  assign first_len = (seq && !page_edge) ? s_len[idx] : n_len[idx];
  assign count     = first_len + (word ? s_len[idx] : cnt_t'(0));
endmodule

// File: rtl/bwg_cycle_calc.sv
module bwg_cycle_calc
  import bwg_pkg::*;
(
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             word,
  input  logic                             seq,
  input  logic [WRAM_W-1:0]                wram_wait,
  input  logic [NS_SEL_W*CART_REGIONS-1:0] ns_sel,
  input  logic [CART_REGIONS-1:0]          s_sel,
  output cnt_t                             count
);
  cnt_t cart_cnt;
  cnt_t wram_base;
  cnt_t wram_cnt;

  bwg_cart_timing u_cart (
    .addr   (addr),
    .word   (word),
    .seq    (seq),
    .ns_sel (ns_sel),
    .s_sel  (s_sel),
    .count  (cart_cnt)
  );

  assign wram_base = cnt_t'(WRAM_SPAN) - cnt_t'(wram_wait);
  assign wram_cnt  = word ? (wram_base << 1) : wram_base;

  always_comb begin
    count = cnt_t'(1);
    if (addr[31:28] != 4'd0) begin
      count = cnt_t'(1);
    end else if (addr[27]) begin
      count = cart_cnt;
    end else begin
      case (addr[26:24])
        3'd2:       count = wram_cnt;
        3'd5, 3'd6: count = word ? cnt_t'(2) : cnt_t'(1);
        default:    count = cnt_t'(1);
      endcase
    end
  end

  always_comb begin
    a_r2_len_range: assert (count != '0 && count <= cnt_t'(2 * WRAM_SPAN))
      else $error("computed access length out of range");
  end
endmodule

// File: rtl/bwg_down_counter.sv
module bwg_down_counter
  import bwg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cnt_t load_val,
  output logic busy,
  output logic done
);
  cnt_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
      done <= (load_val == cnt_t'(1));
    end else if (busy) begin
      cnt  <= cnt - cnt_t'(1);
      busy <= (cnt != cnt_t'(1));
      done <= (cnt == cnt_t'(2));
    end
  end

  a_r9_done_inside: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  a_r9_done_ends: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !busy);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> !done);
  a_r9_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && cnt > cnt_t'(1)) |=> (cnt == $past(cnt) - cnt_t'(1)));
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic                             req_word,
  input  logic                             req_seq,
  input  logic [WRAM_W-1:0]                cfg_wram_wait,
  input  logic [NS_SEL_W*CART_REGIONS-1:0] cfg_ns_sel,
  input  logic [CART_REGIONS-1:0]          cfg_seq_sel,
  output logic                             busy,
  output logic                             done
);
  cnt_t len;
  logic accept;

  assign accept = req_valid && !busy;

  bwg_cycle_calc u_calc (
    .addr      (req_addr),
    .word      (req_word),
    .seq       (req_seq),
    .wram_wait (cfg_wram_wait),
    .ns_sel    (cfg_ns_sel),
    .s_sel     (cfg_seq_sel),
    .count     (len)
  );

  bwg_down_counter u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (len),
    .busy     (busy),
    .done     (done)
  );

  a_r8_take: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);
  a_r8_no_cut: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: tb/bus_wait_gen_bench.sv
module bus_wait_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_seq = 1'b0;
  logic [3:0]  cfg_wram_wait = '0;
  logic [7:0]  cfg_ns_sel = '0;
  logic [3:0]  cfg_seq_sel = '0;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  int model_rem = 0;
  bit compare_on = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_wait_gen u_bus_wait_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .req_seq(req_seq), .cfg_wram_wait(cfg_wram_wait),
    .cfg_ns_sel(cfg_ns_sel), .cfg_seq_sel(cfg_seq_sel), .busy(busy), .done(done)
  );

  function automatic int ref_len(input logic [31:0] a, input bit w, input bit s,
                                 input logic [3:0] ww, input logic [7:0] ns, input logic [3:0] ss);
    int r, nl, sl, first;
    if (a >= 32'h1000_0000 || a < 32'h0200_0000) return 1;
    if (a < 32'h0300_0000) return (16 - int'(ww)) * (w ? 2 : 1);
    if (a < 32'h0500_0000) return 1;
    if (a < 32'h0700_0000) return w ? 2 : 1;
    if (a < 32'h0800_0000) return 1;
    r = int'(a[26:25]);
    case (ns[2*r +: 2])
      2'd0: nl = 5;
      2'd1: nl = 4;
      2'd2: nl = 3;
      default: nl = 9;
    endcase
    if (r == 3) sl = nl;
    else if (ss[r]) sl = 2;
    else sl = (r == 0) ? 3 : (r == 1) ? 5 : 9;
    first = (s && a[16:1] != 0) ? sl : nl;
    return first + (w ? sl : 0);
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // cycle-by-cycle reference: remaining cycles of the running access
  always @(posedge clk) begin
    if (rst) model_rem <= 0;
    else if (model_rem == 0 && req_valid)
      model_rem <= ref_len(req_addr, req_word, req_seq, cfg_wram_wait, cfg_ns_sel, cfg_seq_sel);
    else if (model_rem > 0) model_rem <= model_rem - 1;
  end

  always @(negedge clk) begin
    if (compare_on && !finished) begin
      check("R9 busy per clock", int'(busy), int'(model_rem > 0));
      check("R9 done per clock", int'(done), int'(model_rem == 1));
    end
  end

  // mode 0 plain, 1 rewrite config after accept (R10), 2 poke request while busy (R8)
  task automatic access(input logic [31:0] a, input bit w, input bit s,
                        input int mode, input string req);
    int expected, n, dn, last_dn;
    expected = ref_len(a, w, s, cfg_wram_wait, cfg_ns_sel, cfg_seq_sel);
    @(negedge clk);
    req_addr = a; req_word = w; req_seq = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mode == 1) begin
      cfg_wram_wait = ~cfg_wram_wait;
      cfg_ns_sel    = ~cfg_ns_sel;
      cfg_seq_sel   = ~cfg_seq_sel;
    end
    n = 0; dn = 0; last_dn = 0;
    while (busy && n < 100) begin
      n++;
      if (done) begin dn++; last_dn = n; end
      if (mode == 2 && n == 1) begin
        req_addr = 32'h0E00_0000; req_word = 1'b1; req_seq = 1'b0; req_valid = 1'b1;
      end
      if (mode == 2 && n == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    check({req, " length"}, n, expected);
    check({req, " done pulses"}, dn, 1);
    check({req, " done position"}, last_dn, expected);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare_on = 1'b1;
    check("R11 busy after reset", int'(busy), 0);
    check("R11 done after reset", int'(done), 0);
    cfg_ns_sel = 8'b11_10_01_00;
    cfg_seq_sel = 4'b0101;
    cfg_wram_wait = 4'd13;

    access(32'h0000_1234, 1'b0, 1'b0, 0, "R1 low");
    access(32'h1000_0000, 1'b1, 1'b1, 0, "R1 unmapped edge");
    access(32'hFFFF_FFFC, 1'b1, 1'b0, 0, "R1 top");
    access(32'h01FF_FFFE, 1'b1, 1'b0, 0, "R1 below work RAM");

    access(32'h0200_0000, 1'b1, 1'b0, 0, "R2 word wait13");
    access(32'h02FF_FFFE, 1'b0, 1'b1, 0, "R2 half wait13");
    cfg_wram_wait = 4'd0;
    access(32'h0200_0100, 1'b1, 1'b0, 0, "R2 word wait0");
    access(32'h0200_0102, 1'b0, 1'b0, 0, "R2 half wait0");
    cfg_wram_wait = 4'd15;
    access(32'h0201_0000, 1'b0, 1'b0, 0, "R2 half wait15");

    access(32'h0300_0000, 1'b1, 1'b0, 0, "R3 internal");
    access(32'h04FF_FFFC, 1'b1, 1'b0, 0, "R3 io");
    access(32'h0500_0000, 1'b1, 1'b0, 0, "R3 palette word");
    access(32'h06FF_FFFE, 1'b0, 1'b0, 0, "R3 video half");
    access(32'h0700_0000, 1'b1, 1'b0, 0, "R3 object");

    access(32'h0800_0100, 1'b0, 1'b0, 0, "R4 win0 sel0");
    access(32'h0A00_0100, 1'b0, 1'b0, 0, "R4 win1 sel1");
    access(32'h0C00_0100, 1'b0, 1'b0, 0, "R4 win2 sel2");
    access(32'h0E00_0100, 1'b0, 1'b0, 0, "R4 win3 sel3");

    access(32'h0800_0102, 1'b0, 1'b1, 0, "R5 win0 fast");
    access(32'h0A00_0102, 1'b0, 1'b1, 0, "R5 win1 slow");
    access(32'h0C00_0102, 1'b0, 1'b1, 0, "R5 win2 fast");
    access(32'h0E00_0102, 1'b0, 1'b1, 0, "R5 win3 equals N");
    cfg_seq_sel = 4'b1010;
    cfg_ns_sel = 8'b00_01_10_11;
    access(32'h0800_0102, 1'b0, 1'b1, 0, "R5 win0 slow");
    access(32'h0C00_0102, 1'b0, 1'b1, 0, "R5 win2 slow");
    access(32'h0E00_0102, 1'b0, 1'b1, 0, "R5 win3 sel0");

    access(32'h0802_0000, 1'b0, 1'b1, 0, "R6 page edge");
    access(32'h0802_0001, 1'b0, 1'b1, 0, "R6 page edge bit0");
    access(32'h0802_0002, 1'b0, 1'b1, 0, "R6 after edge");
    access(32'h0A04_0000, 1'b1, 1'b1, 0, "R6 edge word");

    access(32'h0800_0200, 1'b1, 1'b0, 0, "R7 word nonseq");
    access(32'h0C00_0204, 1'b1, 1'b1, 0, "R7 word seq");
    access(32'h0E00_0204, 1'b1, 1'b0, 0, "R7 word win3");

    cfg_wram_wait = 4'd2;
    access(32'h0200_0040, 1'b1, 1'b0, 2, "R8 poke while busy");
    check("R8 idle after poke", int'(busy), 0);
    access(32'h0200_0040, 1'b1, 1'b0, 1, "R10 wram config change");
    access(32'h0C00_0300, 1'b1, 1'b1, 1, "R10 cart config change");

    @(negedge clk);
    req_addr = 32'h0200_0000; req_word = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 busy after mid reset", int'(busy), 0);
    check("R11 done after mid reset", int'(done), 0);
    access(32'h0500_0000, 1'b0, 1'b0, 0, "R11 access after reset");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule